// File: doc/BRIEF.md
# Timer Compare Unit with Event Trigger

This block holds a free-running timer and a compare register of the same width. Every cycle it checks the timer value against the compare value. When the two become equal, it carries out one action chosen by a 4-bit mode. It can set, clear or toggle an output latch. It can raise an interrupt flag and do nothing else. Or it can issue an event trigger, which restarts the timer and asks the converter to begin a conversion.

In trigger mode the compare register acts as the timer's period: the count runs from zero up to the compare value and then restarts. The trigger pulse appears in the cycle in which the match starts. The timer is cleared later, on the first timer tick at or after that cycle. If the compare register is written while this reset is still pending, the reset is dropped and the timer keeps counting.

Software writes the compare value and the mode through two write strobes. The timer moves forward only on cycles where the tick input is high.

Top module: `cmp_event_unit`

## Requirements
- R1: On a cycle with `tick` high and no reset pending, `timer_q` increments by one. It wraps from all ones to zero, and that wrap sets the sticky `ovf_flag`. `ovf_clr` clears the flag, but a wrap in the same cycle wins. With `tick` low, the timer holds its value.
- R2: A match event occurs in a cycle where `timer_q` equals the compare register, the two were not equal in the previous cycle, and the current mode is not 4'b0000. The event fires once per entry into equality, including when the timer is stalled on the matching value.
- R3: Every match event sets the sticky `irq_flag` one cycle later. `irq_clr` clears it, and an event in the same cycle wins.
- R4: On a match event, mode 4'b1000 sets `pin_q`, 4'b1001 clears it and 4'b0010 inverts it. Every other mode leaves `pin_q` unchanged.
- R5: `pin_oe` is high exactly when the current mode is 4'b1000, 4'b1001 or 4'b0010. It is low in 4'b1010 (interrupt only) and in 4'b1011 (event trigger).
- R6: `adc_start` is a combinational pulse. It is high in the cycle of a match event when the mode is 4'b1011 and `adc_en` is high, and low at all other times.
- R7: A match event in mode 4'b1011 schedules a timer reset. The first cycle at or after the event with `tick` high loads zero into the timer instead of incrementing it, and that reset does not set `ovf_flag`.
- R8: Writing the compare register in the event cycle, or in any cycle before the scheduled reset is taken, cancels the reset. If a tick coincides with such a write, the timer increments normally.
- R9: Writing mode 4'b0000 drives `pin_q` low on the next cycle. This write takes priority over a match action in the same cycle. A mode write takes effect on the following cycle.
- R10: After reset, the timer, compare register, mode, `pin_q`, `pin_oe`, `irq_flag`, `ovf_flag` and `adc_start` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_we | input | 1 | Write strobe for the compare register |
| cmp_wdata | input | TW | New compare value |
| mode_we | input | 1 | Write strobe for the mode |
| mode_wdata | input | 4 | New mode value |
| tick | input | 1 | Timer advance enable |
| adc_en | input | 1 | Allows the trigger to pulse `adc_start` |
| irq_clr | input | 1 | Clears `irq_flag` |
| ovf_clr | input | 1 | Clears `ovf_flag` |
| timer_q | output | TW | Current timer value |
| pin_q | output | 1 | Compare output latch |
| pin_oe | output | 1 | Output enable for the latch |
| irq_flag | output | 1 | Sticky compare interrupt flag |
| ovf_flag | output | 1 | Sticky timer wrap flag |
| adc_start | output | 1 | Conversion start pulse |

## Verification
The bench builds the unit with TW = 4. With that width the timer wraps every sixteen ticks, so every compare value from 0 to 15 can be swept under each of the five action modes in a short run. The sweep covers wraps, trigger periods from one to sixteen ticks, ticks that coincide with an event, a stalled timer sitting on a match, and compare writes that land inside the pending-reset window. All of these are checked cycle by cycle against a behavioural model that the bench computes from the requirements.

// File: rtl/cmp_event_unit.sv
`timescale 1ns/1ps
module cmp_event_unit #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_we,
  input  logic [TW-1:0] cmp_wdata,
  input  logic          mode_we,
  input  logic [3:0]    mode_wdata,
  input  logic          tick,
  input  logic          adc_en,
  input  logic          irq_clr,
  input  logic          ovf_clr,
  output logic [TW-1:0] timer_q,
  output logic          pin_q,
  output logic          pin_oe,
  output logic          irq_flag,
  output logic          ovf_flag,
  output logic          adc_start
);

  localparam logic [3:0] M_OFF = 4'b0000;
  localparam logic [3:0] M_SET = 4'b1000;
  localparam logic [3:0] M_CLR = 4'b1001;
  localparam logic [3:0] M_TGL = 4'b0010;
  localparam logic [3:0] M_EVT = 4'b1011;
  localparam logic [TW-1:0] TOP = {TW{1'b1}};

  logic [TW-1:0] cmp_q;
  logic [3:0]    mode_q;
  logic          eq_prev, pend_q;

  wire eq       = (timer_q == cmp_q);
  wire hit      = eq && !eq_prev && (mode_q != M_OFF);
  wire evt_hit  = hit && (mode_q == M_EVT);
  wire pend_now = pend_q || evt_hit;
  wire do_rst   = tick && pend_now && !cmp_we;
  wire wrap     = tick && !do_rst && (timer_q == TOP);

  assign adc_start = evt_hit && adc_en;
  assign pin_oe    = (mode_q == M_SET) || (mode_q == M_CLR) || (mode_q == M_TGL);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      timer_q <= '0;
      cmp_q   <= '0;
      mode_q  <= M_OFF;
      eq_prev <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      eq_prev <= eq;
      if (cmp_we)  cmp_q  <= cmp_wdata;
      if (mode_we) mode_q <= mode_wdata;
      if (do_rst)    timer_q <= '0;
      else if (tick) timer_q <= timer_q + 1'b1;
      pend_q <= pend_now && !do_rst && !cmp_we;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      irq_flag <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      if (hit)          irq_flag <= 1'b1;
      else if (irq_clr) irq_flag <= 1'b0;
      if (wrap)         ovf_flag <= 1'b1;
      else if (ovf_clr) ovf_flag <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pin_q <= 1'b0;
    else if (mode_we && mode_wdata == M_OFF) pin_q <= 1'b0;
    else if (hit)
      case (mode_q)
        M_SET:   pin_q <= 1'b1;
        M_CLR:   pin_q <= 1'b0;
        M_TGL:   pin_q <= ~pin_q;
        default: pin_q <= pin_q;
      endcase

  assert_hold_no_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(timer_q));
  assert_ovf_from_top_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !pend_now && timer_q == TOP) |=> (ovf_flag && timer_q == '0));
  assert_irq_from_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_flag ##1 irq_flag) |-> $past(eq));
  assert_adc_sets_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> irq_flag);
  assert_evt_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && tick && !cmp_we) |=> (timer_q == '0 && $stable(ovf_flag) || ovf_clr && !ovf_flag));
  assert_off_clears_pin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we && mode_wdata == M_OFF) |=> !pin_q);

endmodule

// File: tb/tb_cmp_event_unit.sv
`timescale 1ns/1ps
module tb_cmp_event_unit;
  localparam int TW = 4;
  logic clk = 0, rst_n = 0;
  logic cmp_we = 0, mode_we = 0, tick = 0, adc_en = 0, irq_clr = 0, ovf_clr = 0;
  logic [TW-1:0] cmp_wdata = '0;
  logic [3:0] mode_wdata = '0;
  logic [TW-1:0] timer_q;
  logic pin_q, pin_oe, irq_flag, ovf_flag, adc_start;

  cmp_event_unit #(.TW(TW)) dut (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  int m_tmr = 0, m_cmp = 0, m_mode = 0;
  bit m_prev = 0, m_pend = 0, m_pin = 0, m_irq = 0, m_ovf = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_regs();
    bit oe = (m_mode == 8) || (m_mode == 9) || (m_mode == 2);
    chk(timer_q == m_tmr[TW-1:0], "R1 timer", timer_q, m_tmr);
    chk(ovf_flag == m_ovf, "R1/R7 ovf", ovf_flag, m_ovf);
    chk(irq_flag == m_irq, "R2/R3 irq", irq_flag, m_irq);
    chk(pin_q == m_pin, "R4/R9 pin", pin_q, m_pin);
    chk(pin_oe == oe, "R5 oe", pin_oe, oe);
  endtask

  task automatic step(input bit tk, input bit wc, input int cd, input bit wm, input int md,
                      input bit aen, input bit ic, input bit oc);
    bit match, fire, pend_now, rst_t;
    tick = tk; cmp_we = wc; cmp_wdata = cd[TW-1:0]; mode_we = wm; mode_wdata = md[3:0];
    adc_en = aen; irq_clr = ic; ovf_clr = oc;
    #1;
    match = (m_tmr == m_cmp);
    fire = match && !m_prev && (m_mode != 0);
    chk(adc_start == (fire && m_mode == 11 && aen), "R6 adc", adc_start, fire && m_mode == 11 && aen);
    @(posedge clk);
    pend_now = m_pend || (fire && m_mode == 11);
    rst_t = tk && pend_now && !wc;
    m_prev = match;
    if (fire) m_irq = 1; else if (ic) m_irq = 0;
    if (tk && !rst_t && m_tmr == (1 << TW) - 1) m_ovf = 1; else if (oc) m_ovf = 0;
    if (wm && md == 0) m_pin = 0;
    else if (fire) begin
      if (m_mode == 8) m_pin = 1;
      else if (m_mode == 9) m_pin = 0;
      else if (m_mode == 2) m_pin = !m_pin;
    end
    if (rst_t) m_tmr = 0; else if (tk) m_tmr = (m_tmr + 1) % (1 << TW);
    m_pend = pend_now && !rst_t && !wc;
    if (wc) m_cmp = cd % (1 << TW);
    if (wm) m_mode = md;
    @(negedge clk);
    check_regs();
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual 0 expected 1 (run completion)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int modes[5] = '{8, 9, 2, 10, 11};
    repeat (3) @(negedge clk);
    check_regs();                                    // R10 reset state
    chk(adc_start == 0, "R10 adc", adc_start, 0);
    rst_n = 1;
    @(negedge clk);
    foreach (modes[k]) begin
      for (int c = 0; c < (1 << TW); c++) begin
        step(0, 0, 0, 1, 0, 0, 1, 1);                // R9 mode off
        step(0, 1, c, 1, modes[k], 0, 0, 0);
        for (int i = 0; i < 48; i++)
          step(i % 3 != 1, (i == 20) && c[0], c, 0, 0, i[2], i % 11 == 5, i % 13 == 7);
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 1, 0, 0);   // R2 stalled
      end
    end
    // R8 directed: cancel pending reset
    step(0, 1, 5, 1, 11, 0, 1, 1);
    while (m_tmr != 5) step(1, 0, 0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0, 0);
    step(0, 1, 5, 0, 0, 1, 0, 0);
    step(1, 0, 0, 0, 0, 1, 0, 0);
    chk(timer_q == 6, "R8 cancel", timer_q, 6);
    // R7 directed: reset on tick without ovf
    step(0, 1, 15, 0, 0, 1, 0, 1);
    while (m_tmr != 15) step(1, 0, 0, 0, 0, 1, 0, 0);
    step(1, 0, 0, 0, 0, 1, 0, 0);
    chk(timer_q == 0 && !ovf_flag, "R7 no ovf", {ovf_flag, timer_q}, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule